// File: doc/BRIEF.md
# Partitioned Byte-by-Scalar Multiplier

This block is a small SIMD datapath stage. It treats a 32-bit source word as four unsigned 8-bit lanes and multiplies each one by the same signed 16-bit scalar. The scalar is taken from one half of a second 32-bit source word, and a select bit chooses which half. Every lane product is rounded on its low byte. Sixteen bits are then kept from each product, and the four 16-bit results are packed into one 64-bit word. The result is registered and appears one cycle after the operation is issued.

An enable input reports whether the floating-point unit is enabled. When an operation is issued with the enable low, no result is written. Instead, a trap flag is raised for one cycle, and the result register keeps its previous contents.

Output status comes from a three-state controller:
- `ST_IDLE` means nothing was issued in the previous cycle.
- `ST_DONE` means a result was written in the previous cycle.
- `ST_TRAP` means an issue was refused in the previous cycle.

Every state takes the same three transitions on each clock:
- `GO_DONE` is taken when the input is valid and the unit is enabled.
- `GO_TRAP` is taken when the input is valid and the unit is disabled.
- `GO_IDLE` is taken when the input is not valid.

Top module: `byte_scalar_mul`

## Requirements
- R1: Output lane r (bits 16r+15:16r of `result`) is computed from byte r (bits 8r+7:8r of `src_a`), and that byte is read as an unsigned value from 0 to 255.
- R2: When `sel_hi` = 1, the scalar is `src_b[31:16]`, read as a signed two's-complement 16-bit value.
- R3: When `sel_hi` = 0, the scalar is `src_b[15:0]`, read as a signed two's-complement 16-bit value.
- R4: Each lane is computed in three steps:
  - p = scalar × byte, as a two's-complement product.
  - If p[7:0] > 0x7F, 0x100 is added to p. A low byte of exactly 0x80 therefore rounds up, and 0x7F does not.
  - The lane is bits 23:8 of the adjusted p.
- R5: When `in_valid` = 1 and `fpu_en` = 1 at a clock edge, `result` holds the new value after that edge and `res_valid` = 1 for one cycle.
- R6: When `in_valid` = 1 and `fpu_en` = 0 at a clock edge, the following happens after that edge:
  - `trap` = 1.
  - `res_valid` = 0.
  - `result` keeps its previous value.
- R7: When `in_valid` = 0 at a clock edge, `res_valid` = 0 and `trap` = 0 after that edge, and `result` keeps its value.
- R8: Synchronous active-high reset clears `result` to zero and drives `res_valid` and `trap` low.
- R9: `res_valid` and `trap` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| src_a | input | 32 | Four unsigned byte lanes |
| src_b | input | 32 | Holds the scalar in one of its halves |
| sel_hi | input | 1 | 1 selects the upper half of src_b, 0 the lower half |
| fpu_en | input | 1 | Floating-point unit enabled; 0 refuses the issue |
| result | output | 64 | Four rounded 16-bit lanes |
| res_valid | output | 1 | Result written on the last edge |
| trap | output | 1 | Issue refused on the last edge |

## Verification
The assertions assume that `in_valid`, `fpu_en` and `sel_hi` are driven to known values at every clock edge outside reset. They also assume that `src_a` is stable around the issuing edge. The bench meets these assumptions by changing inputs only mid-cycle, away from the rising edge, and by driving every control input explicitly in each cycle. The zero-byte lane property depends only on the operand bytes, so random operands reach it freely. The directed vectors pin the scalar extremes, the byte extremes and the two rounding-threshold products.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_TRAP = 2'd2
    } bsm_state_t;
endpackage

// File: rtl/bsm_scalar_pick.sv
module bsm_scalar_pick #(
    parameter int SCALAR_W = 16
) (
    input  logic [2*SCALAR_W-1:0]       word_b,
    input  logic                        pick_hi,
    output logic signed [SCALAR_W-1:0]  scalar
);
    always_comb begin
        if (pick_hi)
            scalar = word_b[2*SCALAR_W-1:SCALAR_W];
        else
            scalar = word_b[SCALAR_W-1:0];
    end
endmodule

// File: rtl/bsm_lane.sv
module bsm_lane #(
    parameter int LANE_W   = 8,
    parameter int SCALAR_W = 16
) (
    input  logic [LANE_W-1:0]           lane_in,
    input  logic signed [SCALAR_W-1:0]  scalar,
    output logic [SCALAR_W-1:0]         lane_out
);
    localparam int PROD_W = LANE_W + SCALAR_W;

    logic signed [PROD_W-1:0] sc_ext;
    logic signed [PROD_W-1:0] by_ext;
    logic signed [PROD_W-1:0] prod;
    logic [LANE_W-2:0]        unused_low;

    assign sc_ext = {{LANE_W{scalar[SCALAR_W-1]}}, scalar};
    assign by_ext = {{SCALAR_W{1'b0}}, lane_in};
    // Low PROD_W bits of the product are exact in modular arithmetic
    assign prod   = sc_ext * by_ext;

    // Round when the discarded byte is 0x80 or more
    assign lane_out   = prod[PROD_W-1:LANE_W] + {{(SCALAR_W-1){1'b0}}, prod[LANE_W-1]};
    assign unused_low = prod[LANE_W-2:0];
endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
    import bsm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic fpu_en,
    output logic wr_en,
    output logic res_valid,
    output logic trap
);
    bsm_state_t state_q, state_d;

    always_comb begin
        if (in_valid && fpu_en)
            state_d = ST_DONE;      // GO_DONE
        else if (in_valid)
            state_d = ST_TRAP;      // GO_TRAP
        else
            state_d = ST_IDLE;      // GO_IDLE
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        res_valid = 1'b0;
        trap      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: res_valid = 1'b1;
            ST_TRAP: trap      = 1'b1;
            default: ;
        endcase
    end

    assign wr_en = (state_d == ST_DONE);
endmodule

// File: rtl/byte_scalar_mul.sv
module byte_scalar_mul #(
    parameter int LANE_W   = 8,
    parameter int SCALAR_W = 16,
    parameter int LANES    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [LANES*LANE_W-1:0]    src_a,
    input  logic [2*SCALAR_W-1:0]      src_b,
    input  logic                       sel_hi,
    input  logic                       fpu_en,
    output logic [LANES*SCALAR_W-1:0]  result,
    output logic                       res_valid,
    output logic                       trap
);
    localparam int OUT_W = LANES * SCALAR_W;

    logic signed [SCALAR_W-1:0] scalar;
    logic [OUT_W-1:0]           lanes_d;
    logic                       wr_en;

    bsm_scalar_pick #(.SCALAR_W(SCALAR_W)) i_pick (
        .word_b (src_b),
        .pick_hi(sel_hi),
        .scalar (scalar)
    );

    for (genvar r = 0; r < LANES; r++) begin : g_lane
        bsm_lane #(.LANE_W(LANE_W), .SCALAR_W(SCALAR_W)) i_lane (
            .lane_in (src_a[r*LANE_W +: LANE_W]),
            .scalar  (scalar),
            .lane_out(lanes_d[r*SCALAR_W +: SCALAR_W])
        );
    end

    bsm_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .fpu_en   (fpu_en),
        .wr_en    (wr_en),
        .res_valid(res_valid),
        .trap     (trap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (wr_en)
            result <= lanes_d;
    end
endmodule

// File: rtl/bsm_chk.sv
module bsm_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        fpu_en,
    input logic [31:0] src_a,
    input logic [63:0] result,
    input logic        res_valid,
    input logic        trap
);
    // R9
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && trap));

    // R5
    issue_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fpu_en) |=> (res_valid && !trap));

    // R6
    trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fpu_en) |=> (trap && !res_valid && $stable(result)));

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !trap && $stable(result)));

    // R1
    zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fpu_en && src_a[7:0] == 8'h00) |=> (result[15:0] == 16'h0000));

    // R8
    rst_chk: assert property (@(posedge clk)
        rst |=> (result == 64'h0 && !res_valid && !trap));
endmodule

bind byte_scalar_mul bsm_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .fpu_en   (fpu_en),
    .src_a    (src_a),
    .result   (result),
    .res_valid(res_valid),
    .trap     (trap)
);

// File: tb/test_byte_scalar_mul.sv
module test_byte_scalar_mul;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic        sel_hi;
    logic        fpu_en;
    logic [63:0] result;
    logic        res_valid;
    logic        trap;

    int vectors = 0;
    int miscompares = 0;
    logic [63:0] last_res;
    bit done = 0;

    always #10 clk = ~clk;

    byte_scalar_mul i_byte_scalar_mul (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .sel_hi(sel_hi), .fpu_en(fpu_en), .result(result),
        .res_valid(res_valid), .trap(trap)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input logic hi);
        logic [63:0] o;
        int sc;
        sc = hi ? int'($signed(b[31:16])) : int'($signed(b[15:0]));
        for (int r = 0; r < 4; r++) begin
            int p;
            p = sc * int'(a[8*r +: 8]);
            if ((p & 32'hFF) > 32'h7F) p = p + 32'h100;
            o[16*r +: 16] = p[23:8];
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive mid-cycle, sample 5 ns after the capturing edge
    task automatic op(input logic [31:0] a, input logic [31:0] b, input logic hi,
                      input logic en, input string req);
        in_valid = 1'b1; src_a = a; src_b = b; sel_hi = hi; fpu_en = en;
        @(posedge clk); #5;
        in_valid = 1'b0;
        if (en) begin
            check({req, " R5 valid"}, {63'b0, res_valid}, 64'd1);
            check({req, " R4 data"}, result, ref_mul(a, b, hi));
            last_res = ref_mul(a, b, hi);
        end else begin
            check("R6 trap", {63'b0, trap}, 64'd1);
            check("R6 no valid", {63'b0, res_valid}, 64'd0);
            check("R6 result kept", result, last_res);
        end
        check("R9 exclusive", {63'b0, res_valid & trap}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; sel_hi = 1'b0; fpu_en = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        check("R8 reset result", result, 64'h0);
        check("R8 reset valid", {63'b0, res_valid}, 64'd0);
        check("R8 reset trap", {63'b0, trap}, 64'd0);
        last_res = '0;
        rst = 1'b0;

        // R1 lane ordering: distinct bytes, scalar 0x0100 gives byte<<0 per lane
        op(32'h04030201, 32'h0100_0000, 1'b1, 1'b1, "R1 order");
        check("R1 lanes", result, 64'h0004_0003_0002_0001);
        // R2 upper half picked, lower half garbage
        op(32'hFFFF0000, 32'h8000_1234, 1'b1, 1'b1, "R2 0x8000");
        op(32'hFF00FF01, 32'h7FFF_ABCD, 1'b1, 1'b1, "R2 0x7FFF");
        // R3 lower half picked
        op(32'hFF00FF01, 32'hDEAD_8000, 1'b0, 1'b1, "R3 0x8000");
        op(32'h00FF00FF, 32'h5555_7FFF, 1'b0, 1'b1, "R3 0x7FFF");
        // R4 rounding threshold: low byte 0x7F stays, 0x80 rounds up
        op(32'h00000001, 32'h0000_007F, 1'b0, 1'b1, "R4 0x7F");
        check("R4 0x7F lane", result, 64'h0);
        op(32'h00000001, 32'h0000_0080, 1'b0, 1'b1, "R4 0x80");
        check("R4 0x80 lane", result, 64'h1);
        op(32'h00000001, 32'hFF80_0000, 1'b1, 1'b1, "R4 neg 0x80");
        // R6 trap keeps the prior result
        op(32'h12345678, 32'h1111_2222, 1'b0, 1'b0, "R6");
        // R7 idle cycle
        @(posedge clk); #5;
        check("R7 idle valid", {63'b0, res_valid}, 64'd0);
        check("R7 idle trap", {63'b0, trap}, 64'd0);
        check("R7 idle result", result, last_res);

        for (int i = 0; i < 400; i++) begin
            op($urandom, $urandom, 1'($urandom), ($urandom % 8) != 0, "rand");
            if ((i % 37) == 0) begin
                @(posedge clk); #5;
                check("R7 idle gap", {63'b0, res_valid | trap}, 64'd0);
            end
        end

        // R8 reset mid-run
        rst = 1'b1;
        @(posedge clk); #5;
        rst = 1'b0;
        check("R8 reset again", result, 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule